// File: doc/BRIEF.md
# Strap-Configured Boot Flash Read Sequencer

This block issues read cycles to an external asynchronous NOR-style memory on the first chip-select as soon as reset is released, before any software has run. Three strap inputs are captured once, right after reset release. They fix three properties of the device: the width of its data bus, how address and data share the pins, and whether the memory's wait output is honoured. After that, a simple internal request port starts one read at a time. Each read returns the captured data with a single-cycle done pulse.

Every read follows a fixed schedule of 17 functional-clock ticks. Tick 0 is the clock period that follows the edge that accepted the request. The schedule is wide enough for slow flash parts clocked slowly at boot. The address can be presented in three ways. It can go on a separate address output, which leaves the shared bus for data only. It can go on the shared bus together with a separate upper-address bus. Or it can be split across two pulses of address-valid on the shared bus. All external strobes are active low. The shared bus is modelled as a drive value, a drive enable and a sampled input, so the pad ring can build the tri-state buffer.

Top module: `strapFlashReader`

## Requirements
- R1: The straps are captured on the first rising clock edge after reset deasserts, and changes on them after that have no effect. reqReady stays low until that edge has passed.
- R2: In every mode, csN is low during ticks 1 to 15, advN is low during tick 4, and oeN is low during ticks 6 to 15. Outside these ticks each of them is high.
- R3: A read occupies ticks 0 to 16. reqReady is high only in tick 16 while a cycle runs, and rdDone is a one-cycle pulse in tick 16. A request accepted on the edge that ends tick 16 starts the next tick 0 with no idle period.
- R4: With mux strap 10 (address/data multiplexed), adOut carries bits 15:0 of the presented address during ticks 0 to 5. upperAddr carries bits 26:16 of the presented address for the whole cycle.
- R5: With mux strap 01 (two address phases), advN is also low in tick 1 and oeN is also low in ticks 1 and 2. adOut carries byte-address bits 26:17, zero-extended, in ticks 0 to 2, and byte-address bits 16:1 in ticks 3 to 5. upperAddr is zero.
- R6: With mux strap 00 (separate address), adDrive stays low for the whole cycle. lowAddr carries bits 15:0 of the presented address and upperAddr carries bits 26:16, both for the whole cycle.
- R7: With width strap 1, the presented address is the byte address shifted right by one, and rdData is the full 16-bit bus. With width strap 0, the presented address is the byte address, and rdData is the low byte of the bus with the upper byte zero. Data is sampled on the edge that ends tick 15.
- R8: When the wait-enable strap is 1 and waitIn is high at the edge ending tick 15, the cycle stays in tick 15 with every strobe unchanged, and it resumes once waitIn is low. When the wait-enable strap is 0, waitIn has no effect.
- R9: The reserved mux strap value 11 behaves exactly like 00.
- R10: adDrive is low from tick 6 to the end of the cycle in every mode.
- R11: During reset and while idle, csN, advN and oeN are high, adDrive and rdDone are low, and lowAddr and upperAddr are zero.
- R12: Mux strap 01 uses 16-bit behaviour (address shift and full-width data) even when the width strap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapWide | input | 1 | Width strap: 1 selects a 16-bit device, 0 an 8-bit device |
| strapMux | input | 2 | Address/data sharing strap (00 separate, 01 two-phase, 10 multiplexed, 11 reserved) |
| strapWaitEn | input | 1 | Wait-monitoring strap |
| reqValid | input | 1 | Read request |
| reqAddr | input | ADDR_W | Byte address of the read |
| reqReady | output | 1 | A request is accepted on this edge when reqValid is also high |
| rdData | output | DATA_W | Captured read data |
| rdDone | output | 1 | One-cycle pulse when rdData is new |
| csN | output | 1 | Chip-select, active low |
| advN | output | 1 | Address-valid, active low |
| oeN | output | 1 | Output-enable, active low |
| adDrive | output | 1 | Drive enable for the shared bus |
| adOut | output | DATA_W | Value driven on the shared bus |
| adIn | input | DATA_W | Value sampled from the shared bus |
| upperAddr | output | ADDR_W-DATA_W | Upper address bus |
| lowAddr | output | DATA_W | Low address bits in separate-address mode |
| waitIn | input | 1 | Wait signal from the memory, high means not ready |

## Verification
The bench targets the two-phase mode, where a design that omits the early advN and oeN pulses, or places the 26:17 and 16:1 address halves in the wrong phase, gives the memory the wrong address. It also exercises the two-phase mode with an 8-bit strap, where a design that does not force 16-bit behaviour halves the data and doubles the address. Wait is asserted in tick 15 both with and without monitoring enabled. A design that ignores it truncates the access, and a design that always honours it stalls when it should not. Other cases covered are straps that change after capture, back-to-back reads accepted in tick 16, and the reserved mux code, which a careless decoder would turn into a driven bus.

// File: rtl/strapFlashPkg.sv
package strapFlashPkg;

  // Read-cycle schedule, in ticks counted from the cycle start
  localparam int CS_ON        = 1;
  localparam int CS_OFF       = 16;
  localparam int ADV_ON       = 4;
  localparam int ADV_OFF      = 5;
  localparam int OE_ON        = 6;
  localparam int OE_OFF       = 16;
  localparam int SAMPLE_TICK  = 15;
  localparam int CYCLE_TICKS  = 17;
  // Extra first address phase of the two-phase mode
  localparam int AAD_ADV_ON   = 1;
  localparam int AAD_ADV_OFF  = 2;
  localparam int AAD_OE_ON    = 1;
  localparam int AAD_OE_OFF   = 3;

  localparam int TICK_W = $clog2(CYCLE_TICKS);

  typedef enum logic [1:0] {
    MODE_SEP = 2'b00,
    MODE_AAD = 2'b01,
    MODE_ADM = 2'b10
  } busMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic inCycle;     // a read is running
    logic cs;          // chip-select asserted
    logic adv;         // address-valid asserted
    logic oe;          // output-enable asserted
    logic drive;       // block owns the shared bus
    logic firstPhase;  // two-phase mode: high half of the address
    logic atSample;    // current tick is the data sample tick
    logic load;        // request accepted on this edge
  } strobe_t;

endpackage

// File: rtl/strapFlashCtrl.sv
module strapFlashCtrl
  import strapFlashPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     strapWide,
  input  logic [1:0] strapMux,
  input  logic     strapWaitEn,
  input  logic     reqValid,
  input  logic     waitIn,
  output logic     reqReady,
  output logic     stall,
  output logic     wordMode,
  output busMode_t busMode,
  output strobe_t  strb
);

  logic              active;
  logic              strapsTaken;
  logic              waitMonQ;
  logic [TICK_W-1:0] tickQ;
  logic [TICK_W-1:0] nxtTick;
  logic              nxtActive;
  logic              lastTick;
  logic              accept;
  logic              isAad;
  logic              csQ, advQ, oeQ, driveQ, firstQ;
  logic              nCs, nAdv, nOe, nDrive, nFirst;

  function automatic logic inWin(input logic [TICK_W-1:0] t, input int lo, input int hi);
    return (t >= TICK_W'(lo)) && (t < TICK_W'(hi));
  endfunction

  // Straps: captured once on the first edge after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapsTaken <= 1'b0;
      busMode     <= MODE_SEP;
      wordMode    <= 1'b0;
      waitMonQ    <= 1'b0;
    end else if (!strapsTaken) begin
      strapsTaken <= 1'b1;
      case (strapMux)
        2'b01:   busMode <= MODE_AAD;
        2'b10:   busMode <= MODE_ADM;
        default: busMode <= MODE_SEP;
      endcase
      wordMode <= strapWide | (strapMux == 2'b01);
      waitMonQ <= strapWaitEn;
    end
  end

  // Tick sequencing
  always_comb begin
    lastTick = active && (tickQ == TICK_W'(CYCLE_TICKS - 1));
    stall    = active && (tickQ == TICK_W'(SAMPLE_TICK)) && waitMonQ && waitIn;
    reqReady = strapsTaken && (!active || lastTick);
    accept   = reqValid && reqReady;
    if (accept) begin
      nxtActive = 1'b1;
      nxtTick   = '0;
    end else if (lastTick) begin
      nxtActive = 1'b0;
      nxtTick   = '0;
    end else begin
      nxtActive = active;
      nxtTick   = (active && !stall) ? tickQ + TICK_W'(1) : tickQ;
    end
  end

  // Strobes are decoded from the next tick and registered
  always_comb begin
    isAad  = (busMode == MODE_AAD);
    nCs    = nxtActive && inWin(nxtTick, CS_ON, CS_OFF);
    nAdv   = nxtActive && (inWin(nxtTick, ADV_ON, ADV_OFF) ||
                           (isAad && inWin(nxtTick, AAD_ADV_ON, AAD_ADV_OFF)));
    nOe    = nxtActive && (inWin(nxtTick, OE_ON, OE_OFF) ||
                           (isAad && inWin(nxtTick, AAD_OE_ON, AAD_OE_OFF)));
    nDrive = nxtActive && (busMode != MODE_SEP) && (nxtTick < TICK_W'(OE_ON));
    nFirst = nxtActive && isAad && (nxtTick < TICK_W'(AAD_OE_OFF));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      tickQ  <= '0;
      csQ    <= 1'b0;
      advQ   <= 1'b0;
      oeQ    <= 1'b0;
      driveQ <= 1'b0;
      firstQ <= 1'b0;
    end else begin
      active <= nxtActive;
      tickQ  <= nxtTick;
      csQ    <= nCs;
      advQ   <= nAdv;
      oeQ    <= nOe;
      driveQ <= nDrive;
      firstQ <= nFirst;
    end
  end

  always_comb begin
    strb.inCycle    = active;
    strb.cs         = csQ;
    strb.adv        = advQ;
    strb.oe         = oeQ;
    strb.drive      = driveQ;
    strb.firstPhase = firstQ;
    strb.atSample   = active && (tickQ == TICK_W'(SAMPLE_TICK));
    strb.load       = accept;
  end

endmodule

// File: rtl/strapFlashDpath.sv
module strapFlashDpath
  import strapFlashPkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic                     stall,
  input  logic                     wordMode,
  input  busMode_t                 busMode,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     csN,
  output logic                     advN,
  output logic                     oeN,
  output logic                     adDrive,
  output logic [DATA_W-1:0]        adOut,
  output logic [DATA_W-1:0]        lowAddr,
  output logic [ADDR_W-DATA_W-1:0] upperAddr,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdDone
);

  localparam int UPPER_W = ADDR_W - DATA_W;
  localparam int HALF_W  = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] presAddr;
  logic [DATA_W-1:0] aadHi;
  logic [DATA_W-1:0] aadLo;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] capVal;
  logic              doneQ;
  logic              capture;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (strb.load) addrQ <= reqAddr;
  end

  always_comb begin
    presAddr = wordMode ? (addrQ >> 1) : addrQ;
    aadHi    = DATA_W'(addrQ >> (DATA_W + 1));
    aadLo    = addrQ[DATA_W:1];
  end

  // Pin drive
  always_comb begin
    csN     = ~strb.cs;
    advN    = ~strb.adv;
    oeN     = ~strb.oe;
    adDrive = strb.drive;
    if (!strb.drive)
      adOut = '0;
    else if (busMode == MODE_AAD)
      adOut = strb.firstPhase ? aadHi : aadLo;
    else
      adOut = presAddr[DATA_W-1:0];
    upperAddr = (strb.inCycle && busMode != MODE_AAD) ? presAddr[ADDR_W-1:DATA_W] : UPPER_W'(0);
    lowAddr   = (strb.inCycle && busMode == MODE_SEP) ? presAddr[DATA_W-1:0] : '0;
  end

  // Data capture, lane selected by device width
  assign capture = strb.atSample && !stall;

  generate
    if (DATA_W > HALF_W) begin : g_lanes
      assign capVal = wordMode ? adIn : {{(DATA_W-HALF_W){1'b0}}, adIn[HALF_W-1:0]};
    end else begin : g_single
      assign capVal = adIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= capture;
      if (capture) dataQ <= capVal;
    end
  end

  assign rdData = dataQ;
  assign rdDone = doneQ;

endmodule

// File: rtl/strapFlashReader.sv
module strapFlashReader
  import strapFlashPkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     strapWide,
  input  logic [1:0]               strapMux,
  input  logic                     strapWaitEn,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  output logic                     reqReady,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdDone,
  output logic                     csN,
  output logic                     advN,
  output logic                     oeN,
  output logic                     adDrive,
  output logic [DATA_W-1:0]        adOut,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] upperAddr,
  output logic [DATA_W-1:0]        lowAddr,
  input  logic                     waitIn
);

  strobe_t  strb;
  busMode_t busMode;
  logic     stall;
  logic     wordMode;

  strapFlashCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strapWide  (strapWide),
    .strapMux   (strapMux),
    .strapWaitEn(strapWaitEn),
    .reqValid   (reqValid),
    .waitIn     (waitIn),
    .reqReady   (reqReady),
    .stall      (stall),
    .wordMode   (wordMode),
    .busMode    (busMode),
    .strb       (strb)
  );

  strapFlashDpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stall    (stall),
    .wordMode (wordMode),
    .busMode  (busMode),
    .reqAddr  (reqAddr),
    .adIn     (adIn),
    .csN      (csN),
    .advN     (advN),
    .oeN      (oeN),
    .adDrive  (adDrive),
    .adOut    (adOut),
    .lowAddr  (lowAddr),
    .upperAddr(upperAddr),
    .rdData   (rdData),
    .rdDone   (rdDone)
  );

endmodule

// File: rtl/strapFlashChecker.sv
module strapFlashChecker
  import strapFlashPkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     csN,
  input logic     advN,
  input logic     oeN,
  input logic     adDrive,
  input logic     rdDone,
  input logic     reqReady,
  input logic     stall,
  input strobe_t  strb,
  input busMode_t busMode
);

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> $stable(busMode)); // R1

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rstN)
    (!advN || !oeN) |-> !csN); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone); // R3

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> reqReady); // R3

  AST_SEP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == MODE_SEP) |-> !adDrive); // R6

  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (strb.atSample && $stable({csN, advN, oeN}))); // R8

  AST_BUS_FREE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> !adDrive); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inCycle |-> (csN && advN && oeN && !adDrive)); // R11

endmodule

bind strapFlashReader strapFlashChecker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .advN    (advN),
  .oeN     (oeN),
  .adDrive (adDrive),
  .rdDone  (rdDone),
  .reqReady(reqReady),
  .stall   (stall),
  .strb    (strb),
  .busMode (busMode)
);

// File: tb/strapFlashReader_tb.sv
`timescale 1ns/1ps
module strapFlashReader_tb;

  localparam int AW = 27;
  localparam int DW = 16;

  typedef struct packed {
    logic          wide;
    logic [1:0]    mux;
    logic          waitEn;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [2:0]    stall;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'b10, 1'b0, 27'h4ABCDE6, 16'hBEEF, 3'd0},  // multiplexed, 16-bit
    '{1'b0, 2'b10, 1'b0, 27'h012345F, 16'h12A5, 3'd0},  // multiplexed, 8-bit
    '{1'b1, 2'b01, 1'b0, 27'h7F0AA54, 16'hC3C3, 3'd0},  // two-phase
    '{1'b0, 2'b01, 1'b0, 27'h1234567, 16'h5AA5, 3'd0},  // two-phase, 8-bit strap
    '{1'b1, 2'b00, 1'b0, 27'h2468ACE, 16'h0F0F, 3'd0},  // separate address
    '{1'b0, 2'b11, 1'b0, 27'h3333333, 16'h9876, 3'd0},  // reserved code
    '{1'b1, 2'b10, 1'b1, 27'h0000002, 16'h4321, 3'd3},  // wait honoured
    '{1'b1, 2'b10, 1'b0, 27'h0000004, 16'h1111, 3'd3}   // wait ignored
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          strapWide = 1'b0;
  logic [1:0]    strapMux = 2'b00;
  logic          strapWaitEn = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqReady;
  logic [DW-1:0] rdData;
  logic          rdDone;
  logic          csN, advN, oeN, adDrive;
  logic [DW-1:0] adOut;
  logic [DW-1:0] adIn = '0;
  logic [AW-DW-1:0] upperAddr;
  logic [DW-1:0] lowAddr;
  logic          waitIn = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  strapFlashReader u_dut (
    .clk(clk), .rstN(rstN), .strapWide(strapWide), .strapMux(strapMux),
    .strapWaitEn(strapWaitEn), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rdData(rdData), .rdDone(rdDone), .csN(csN),
    .advN(advN), .oeN(oeN), .adDrive(adDrive), .adOut(adOut), .adIn(adIn),
    .upperAddr(upperAddr), .lowAddr(lowAddr), .waitIn(waitIn)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doReset(input logic w, input logic [1:0] m, input logic we);
    strapWide = w; strapMux = m; strapWaitEn = we;
    reqValid = 1'b0; waitIn = 1'b0;
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Starts on a negedge with the block ready; ends on the negedge of tick 16
  task automatic runRead(input logic w, input logic [1:0] m, input logic we,
                         input logic [AW-1:0] addr, input logic [DW-1:0] din,
                         input int stallN, input string forceTag);
    logic aad, sep, wordA;
    logic [AW-1:0] pres;
    string sTag, aTag, dTag, bTag;
    bit sBad, aBad, bBad;
    logic [31:0] sAct, sExp, aAct, aExp, bAct, bExp;
    int t, hold;
    logic eCs, eAdv, eOe, eDrv, eEnd;
    logic [DW-1:0] eAd, eLow, eData;
    logic [AW-DW-1:0] eUp;
    aad   = (m == 2'b01);
    sep   = (m == 2'b00) || (m == 2'b11);
    wordA = w || aad;
    pres  = wordA ? (addr >> 1) : addr;
    sTag  = (stallN > 0) ? "R8" : (aad ? "R5" : "R2");
    aTag  = aad ? (w ? "R5" : "R12") : (sep ? ((m == 2'b11) ? "R9" : "R6") : "R4");
    dTag  = aad && !w ? "R12" : "R7";
    bTag  = "R10";
    if (forceTag != "") begin sTag = forceTag; aTag = forceTag; dTag = forceTag; bTag = forceTag; end
    eData = wordA ? din : {8'h00, din[7:0]};
    eUp   = aad ? '0 : pres[AW-1:DW];
    eLow  = sep ? pres[DW-1:0] : '0;
    sBad = 0; aBad = 0; bBad = 0;
    sAct = 0; sExp = 0; aAct = 0; aExp = 0; bAct = 0; bExp = 0;

    check(reqReady === 1'b1, "R3", "ready before request", {31'b0, reqReady}, 1);
    adIn = din; reqAddr = addr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    t = 0; hold = 0;
    forever begin
      eCs  = (t >= 1) && (t < 16);
      eAdv = (t == 4) || (aad && t == 1);
      eOe  = ((t >= 6) && (t < 16)) || (aad && (t == 1 || t == 2));
      eDrv = !sep && (t < 6);
      eEnd = (t == 16);
      eAd  = aad ? ((t < 3) ? DW'(addr >> 17) : addr[16:1]) : pres[DW-1:0];
      if (!sBad && ({csN, advN, oeN, reqReady, rdDone} !== {!eCs, !eAdv, !eOe, eEnd, eEnd})) begin
        sBad = 1;
        sAct = {t[7:0], 19'b0, csN, advN, oeN, reqReady, rdDone};
        sExp = {t[7:0], 19'b0, !eCs, !eAdv, !eOe, eEnd, eEnd};
      end
      if (!bBad && (adDrive !== eDrv)) begin
        bBad = 1; bAct = {t[7:0], 23'b0, adDrive}; bExp = {t[7:0], 23'b0, eDrv};
      end
      if (!aBad && ((eDrv && adOut !== eAd) || upperAddr !== eUp || lowAddr !== eLow)) begin
        aBad = 1;
        aAct = (eDrv && adOut !== eAd) ? {16'b0, adOut} : (upperAddr !== eUp ? {21'b0, upperAddr} : {16'b0, lowAddr});
        aExp = (eDrv && adOut !== eAd) ? {16'b0, eAd}   : (upperAddr !== eUp ? {21'b0, eUp}       : {16'b0, eLow});
      end
      if (t == 16) break;
      if (t == 15 && hold < stallN) begin waitIn = 1'b1; hold++; end
      else waitIn = 1'b0;
      @(negedge clk);
      if (!(t == 15 && waitIn && we)) t++;
    end
    waitIn = 1'b0;
    check(!sBad, sTag, "strobe schedule {tick,cs,adv,oe,ready,done}", sAct, sExp);
    check(!bBad, bTag, "bus drive window {tick,drive}", bAct, bExp);
    check(!aBad, aTag, "address presentation", aAct, aExp);
    check(rdData === eData, dTag, "read data", {16'b0, rdData}, {16'b0, eData});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R11: reset state
    strapWide = 1; strapMux = 2'b10; strapWaitEn = 0;
    repeat (2) @(negedge clk);
    check({csN, advN, oeN} === 3'b111, "R11", "strobes in reset", {29'b0, csN, advN, oeN}, 7);
    check({adDrive, rdDone, reqReady} === 3'b000, "R11", "drive/done/ready in reset",
          {29'b0, adDrive, rdDone, reqReady}, 0);
    check(upperAddr === '0 && lowAddr === '0, "R11", "address outputs in reset",
          {5'b0, upperAddr, lowAddr}, 0);
    // R1: not ready until the first edge after release
    rstN = 1'b1;
    check(reqReady === 1'b0, "R1", "ready before first edge", {31'b0, reqReady}, 0);
    @(negedge clk);
    check(reqReady === 1'b1, "R1", "ready after first edge", {31'b0, reqReady}, 1);
    check({csN, advN, oeN, adDrive} === 4'b1110, "R11", "idle outputs",
          {28'b0, csN, advN, oeN, adDrive}, 14);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      doReset(VECS[i].wide, VECS[i].mux, VECS[i].waitEn);
      runRead(VECS[i].wide, VECS[i].mux, VECS[i].waitEn, VECS[i].addr,
              VECS[i].din, int'(VECS[i].stall), "");
    end

    // R1: straps changed after capture have no effect
    doReset(1'b1, 2'b10, 1'b0);
    strapWide = 1'b0; strapMux = 2'b00; strapWaitEn = 1'b1;
    runRead(1'b1, 2'b10, 1'b0, 27'h55AA55A, 16'hA5A5, 2, "R1");

    // R3: back-to-back reads, second accepted in tick 16
    doReset(1'b1, 2'b01, 1'b0);
    runRead(1'b1, 2'b01, 1'b0, 27'h6000002, 16'h7E7E, 0, "");
    runRead(1'b1, 2'b01, 1'b0, 27'h0FFFFFE, 16'h8181, 0, "R3");
    @(negedge clk);
    check({csN, advN, oeN, adDrive, rdDone} === 5'b11100, "R11", "idle after last read",
          {27'b0, csN, advN, oeN, adDrive, rdDone}, 28);
    check(upperAddr === '0 && lowAddr === '0, "R11", "address outputs idle",
          {5'b0, upperAddr, lowAddr}, 0);

    // R8: longer wait with 8-bit separate-address device
    doReset(1'b0, 2'b00, 1'b1);
    runRead(1'b0, 2'b00, 1'b1, 27'h00001FF, 16'h33CC, 5, "R8");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule